// File: doc/BRIEF.md
# Integer Bytecode Execute Unit

This block decodes and runs the integer part of a 32-bit fixed-width bytecode. It holds sixteen 32-bit registers. Each accepted instruction word is decoded, its register operands are read, and in the same cycle the unit drives a register write-back, a branch decision with its target, or a memory request. Register writes take effect at the next rising clock edge. Branch targets come from a base register plus a signed offset; the program counter does not enter the calculation.

A three-state machine sequences the work. Reset puts it in `ST_RUN`. There it accepts one instruction per cycle while `instr_valid` is high. A load issues its read in `ST_RUN` and moves to `ST_LOAD_WAIT` (transition RUN->LOAD_WAIT). The machine stays there until `ld_valid` returns the word, which is written to the destination register as it leaves (LOAD_WAIT->RUN). A halt instruction moves it to `ST_HALTED` (RUN->HALTED). Only reset leaves `ST_HALTED`. Multiply, divide, float, user-defined and reserved opcodes are not executed; they raise `illegal` and change nothing.

Top module: `bcx_exec_unit`

## Requirements
- R1: After reset, every register reads zero, `halted` is 0 and `instr_ready` is 1.
- R2: Opcode 0x10 writes imm16 (bits 15:0) into Rd[31:16], and opcode 0x11 writes it into Rd[15:0]. The mode field in bits 19:16 sets the other half: 0x0 clears it, 0xF fills it with ones, and 0x1 keeps its old value.
- R3: The opcode sits in bits 31:24, Rd in 23:20, Ra in 19:16, Rb in 15:12 and imm12 in 11:0. Opcode 0x12 copies Ra into Rd.
- R4: Opcodes 0x20 and 0x21 write Ra+Rb+C to Rd. Opcodes 0x22 and 0x23 write Ra-Rb-C to Rd. C is imm12, sign-extended for the even opcodes and zero-extended for the odd ones.
- R5: Opcodes 0x40, 0x41 and 0x42 write Ra AND Rb, Ra OR Rb and Ra XOR Rb to Rd. Opcode 0x43 writes NOT Ra to Rd.
- R6: Opcodes 0x48 and 0x4A shift Ra left. Opcode 0x49 shifts Ra right and copies bit 31 into the vacated bits. Opcode 0x4B shifts Ra right and fills with zeros. The shift amount is Rb[4:0] only.
- R7: Opcodes 0x50, 0x51 and 0x52 raise `br_taken` when Ra equals Rb, when Ra differs from Rb, and when Ra is greater than Rb as a signed number. `br_target` is Rd plus the sign-extended imm12. A branch writes no register.
- R8: Opcode 0x18 raises `mem_req` with `mem_we`=1. The address is Ra plus the sign-extended imm16 and `mem_wdata` is Rd.
- R9: Opcode 0x14 raises `mem_req` with `mem_we`=0 for one cycle at the address Ra plus the sign-extended imm16. `instr_ready` then stays low and incoming instructions are ignored until `ld_valid`. `ld_data` is written to Rd in that cycle.
- R10: Opcode 0x00 halts. From the next cycle `halted` stays high until reset, and no register write, memory request or branch occurs.
- R11: Any other opcode, and 0x10/0x11 with a mode other than 0x0, 0xF or 0x1, raises `illegal`. Such an instruction writes no register, makes no memory request and takes no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| wb_en | output | 1 | Register write this cycle |
| wb_idx | output | 4 | Register being written |
| wb_data | output | 32 | Value being written |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | 32 | Branch destination address |
| halted | output | 1 | Unit is stopped |
| illegal | output | 1 | Current instruction is not executable |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| ld_valid | input | 1 | Load data returned |
| ld_data | input | 32 | Returned load word |

## Verification
The hardest case to reach is an instruction arriving while a load is still outstanding. The port must show that the instruction was dropped, and the final value of its destination register must also show it. The bench issues a load, then holds `ld_valid` low for one cycle while it presents a copy instruction. It then returns the data and stores both destination registers out through `mem_wdata`. One register must hold the returned word and the other its old value. The halted state is reached in a similar way: writes and stores are offered after the halt, and the bench checks that nothing comes out.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 16;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [7:0] OP_HALT  = 8'h00;
    localparam logic [7:0] OP_SETHI = 8'h10;
    localparam logic [7:0] OP_SETLO = 8'h11;
    localparam logic [7:0] OP_COPY  = 8'h12;
    localparam logic [7:0] OP_LOAD  = 8'h14;
    localparam logic [7:0] OP_STORE = 8'h18;
    localparam logic [7:0] OP_ADDS  = 8'h20;
    localparam logic [7:0] OP_ADDU  = 8'h21;
    localparam logic [7:0] OP_SUBS  = 8'h22;
    localparam logic [7:0] OP_SUBU  = 8'h23;
    localparam logic [7:0] OP_AND   = 8'h40;
    localparam logic [7:0] OP_OR    = 8'h41;
    localparam logic [7:0] OP_XOR   = 8'h42;
    localparam logic [7:0] OP_NOT   = 8'h43;
    localparam logic [7:0] OP_ASL   = 8'h48;
    localparam logic [7:0] OP_ASR   = 8'h49;
    localparam logic [7:0] OP_LSL   = 8'h4A;
    localparam logic [7:0] OP_LSR   = 8'h4B;
    localparam logic [7:0] OP_BEQ   = 8'h50;
    localparam logic [7:0] OP_BNE   = 8'h51;
    localparam logic [7:0] OP_BGT   = 8'h52;

    localparam logic [3:0] MODE_CLEAR = 4'h0;
    localparam logic [3:0] MODE_KEEP  = 4'h1;
    localparam logic [3:0] MODE_FILL  = 4'hF;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_LOAD_WAIT = 2'd1,
        ST_HALTED    = 2'd2
    } exec_state_e;

    typedef enum logic [4:0] {
        CLS_ILLEGAL,
        CLS_HALT,
        CLS_SETHI,
        CLS_SETLO,
        CLS_COPY,
        CLS_LOAD,
        CLS_STORE,
        CLS_ADD,
        CLS_SUB,
        CLS_AND,
        CLS_OR,
        CLS_XOR,
        CLS_NOT,
        CLS_SHL,
        CLS_SHRA,
        CLS_SHRL,
        CLS_BRANCH
    } op_class_e;

    typedef enum logic [1:0] {
        BR_EQ = 2'd0,
        BR_NE = 2'd1,
        BR_GT = 2'd2
    } br_kind_e;

    typedef struct packed {
        op_class_e cls;
        logic      imm_signed;
        br_kind_e  br_kind;
        logic      writes_reg;
    } decoded_t;

endpackage

// File: rtl/bcx_decode.sv
module bcx_decode
    import bcx_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] mode,
    output decoded_t   dec
);

    logic mode_ok;

    always_comb begin
        mode_ok = (mode == MODE_CLEAR) || (mode == MODE_FILL) || (mode == MODE_KEEP);
    end

    always_comb begin
        dec = '{cls: CLS_ILLEGAL, imm_signed: 1'b0, br_kind: BR_EQ, writes_reg: 1'b0};
        unique case (opcode)
            OP_HALT:  dec.cls = CLS_HALT;
            OP_SETHI: if (mode_ok) begin dec.cls = CLS_SETHI; dec.writes_reg = 1'b1; end
            OP_SETLO: if (mode_ok) begin dec.cls = CLS_SETLO; dec.writes_reg = 1'b1; end
            OP_COPY:  begin dec.cls = CLS_COPY;  dec.writes_reg = 1'b1; end
            OP_LOAD:  dec.cls = CLS_LOAD;
            OP_STORE: dec.cls = CLS_STORE;
            OP_ADDS:  begin dec.cls = CLS_ADD; dec.imm_signed = 1'b1; dec.writes_reg = 1'b1; end
            OP_ADDU:  begin dec.cls = CLS_ADD; dec.writes_reg = 1'b1; end
            OP_SUBS:  begin dec.cls = CLS_SUB; dec.imm_signed = 1'b1; dec.writes_reg = 1'b1; end
            OP_SUBU:  begin dec.cls = CLS_SUB; dec.writes_reg = 1'b1; end
            OP_AND:   begin dec.cls = CLS_AND; dec.writes_reg = 1'b1; end
            OP_OR:    begin dec.cls = CLS_OR;  dec.writes_reg = 1'b1; end
            OP_XOR:   begin dec.cls = CLS_XOR; dec.writes_reg = 1'b1; end
            OP_NOT:   begin dec.cls = CLS_NOT; dec.writes_reg = 1'b1; end
            OP_ASL,
            OP_LSL:   begin dec.cls = CLS_SHL;  dec.writes_reg = 1'b1; end
            OP_ASR:   begin dec.cls = CLS_SHRA; dec.writes_reg = 1'b1; end
            OP_LSR:   begin dec.cls = CLS_SHRL; dec.writes_reg = 1'b1; end
            OP_BEQ:   begin dec.cls = CLS_BRANCH; dec.br_kind = BR_EQ; end
            OP_BNE:   begin dec.cls = CLS_BRANCH; dec.br_kind = BR_NE; end
            OP_BGT:   begin dec.cls = CLS_BRANCH; dec.br_kind = BR_GT; end
            default:  dec.cls = CLS_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/bcx_regfile.sv
module bcx_regfile #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_d,
    input  logic [IDX_W-1:0]  ridx_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_d,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_d = regs[ridx_d];
        rdata_a = regs[ridx_a];
        rdata_b = regs[ridx_b];
    end

endmodule

// File: rtl/bcx_alu.sv
module bcx_alu
    import bcx_pkg::*;
(
    input  decoded_t        dec,
    input  logic [3:0]      mode,
    input  logic [11:0]     imm12,
    input  logic [15:0]     imm16,
    input  logic [XLEN-1:0] rd_val,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    output logic [XLEN-1:0] result,
    output logic            br_cond,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] mem_addr
);

    localparam int HALF_W = XLEN / 2;
    localparam int SHAM_W = $clog2(XLEN);

    logic [XLEN-1:0]   imm12_sx;
    logic [XLEN-1:0]   imm12_ext;
    logic [XLEN-1:0]   imm16_sx;
    logic [HALF_W-1:0] other_hi;
    logic [HALF_W-1:0] other_lo;
    logic [SHAM_W-1:0] sham;

    always_comb begin
        imm12_sx  = {{(XLEN-12){imm12[11]}}, imm12};
        imm12_ext = dec.imm_signed ? imm12_sx : {{(XLEN-12){1'b0}}, imm12};
        imm16_sx  = {{(XLEN-16){imm16[15]}}, imm16};
        sham      = rb_val[SHAM_W-1:0];
    end

    // Fill value for the half not written by a partial-word set.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: begin other_hi = '0; other_lo = '0; end
            MODE_FILL:  begin other_hi = '1; other_lo = '1; end
            default:    begin other_hi = rd_val[XLEN-1:HALF_W]; other_lo = rd_val[HALF_W-1:0]; end
        endcase
    end

    always_comb begin
        result = '0;
        unique case (dec.cls)
            CLS_SETHI: result = {imm16, other_lo};
            CLS_SETLO: result = {other_hi, imm16};
            CLS_COPY:  result = ra_val;
            CLS_ADD:   result = ra_val + rb_val + imm12_ext;
            CLS_SUB:   result = ra_val - rb_val - imm12_ext;
            CLS_AND:   result = ra_val & rb_val;
            CLS_OR:    result = ra_val | rb_val;
            CLS_XOR:   result = ra_val ^ rb_val;
            CLS_NOT:   result = ~ra_val;
            CLS_SHL:   result = ra_val << sham;
            CLS_SHRA:  result = $unsigned($signed(ra_val) >>> sham);
            CLS_SHRL:  result = ra_val >> sham;
            default:   result = '0;
        endcase
    end

    always_comb begin
        unique case (dec.br_kind)
            BR_EQ:   br_cond = (ra_val == rb_val);
            BR_NE:   br_cond = (ra_val != rb_val);
            BR_GT:   br_cond = ($signed(ra_val) > $signed(rb_val));
            default: br_cond = 1'b0;
        endcase
        br_target = rd_val + imm12_sx;
        mem_addr  = ra_val + imm16_sx;
    end

endmodule

// File: rtl/bcx_exec_unit.sv
module bcx_exec_unit
    import bcx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output logic        instr_ready,
    output logic        wb_en,
    output logic [3:0]  wb_idx,
    output logic [31:0] wb_data,
    output logic        br_taken,
    output logic [31:0] br_target,
    output logic        halted,
    output logic        illegal,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        ld_valid,
    input  logic [31:0] ld_data
);

    exec_state_e       state_q;
    exec_state_e       state_d;
    logic [RIDX_W-1:0] ld_dest_q;

    logic [7:0]        f_op;
    logic [RIDX_W-1:0] f_rd;
    logic [RIDX_W-1:0] f_ra;
    logic [RIDX_W-1:0] f_rb;
    logic [11:0]       f_imm12;
    logic [15:0]       f_imm16;

    decoded_t          dec;
    logic [XLEN-1:0]   rd_val;
    logic [XLEN-1:0]   ra_val;
    logic [XLEN-1:0]   rb_val;
    logic [XLEN-1:0]   alu_res;
    logic              alu_br;
    logic [XLEN-1:0]   alu_tgt;
    logic [XLEN-1:0]   alu_addr;
    logic              accept;

    always_comb begin
        f_op    = instr[31:24];
        f_rd    = instr[23:20];
        f_ra    = instr[19:16];
        f_rb    = instr[15:12];
        f_imm12 = instr[11:0];
        f_imm16 = instr[15:0];
        accept  = instr_valid && (state_q == ST_RUN);
    end

    bcx_decode u_dec (
        .opcode (f_op),
        .mode   (f_ra),
        .dec    (dec)
    );

    bcx_regfile #(
        .NREGS  (NREGS),
        .DATA_W (XLEN)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_en),
        .widx    (wb_idx),
        .wdata   (wb_data),
        .ridx_d  (f_rd),
        .ridx_a  (f_ra),
        .ridx_b  (f_rb),
        .rdata_d (rd_val),
        .rdata_a (ra_val),
        .rdata_b (rb_val)
    );

    bcx_alu u_alu (
        .dec       (dec),
        .mode      (f_ra),
        .imm12     (f_imm12),
        .imm16     (f_imm16),
        .rd_val    (rd_val),
        .ra_val    (ra_val),
        .rb_val    (rb_val),
        .result    (alu_res),
        .br_cond   (alu_br),
        .br_target (alu_tgt),
        .mem_addr  (alu_addr)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept && dec.cls == CLS_HALT) begin
                    state_d = ST_HALTED;
                end else if (accept && dec.cls == CLS_LOAD) begin
                    state_d = ST_LOAD_WAIT;
                end
            end
            ST_LOAD_WAIT: if (ld_valid) state_d = ST_RUN;
            ST_HALTED:    state_d = ST_HALTED;
            default:      state_d = ST_RUN;
        endcase
    end

    // State register and pending load destination.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            ld_dest_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && dec.cls == CLS_LOAD) begin
                ld_dest_q <= f_rd;
            end
        end
    end

    // Outputs.
    always_comb begin
        instr_ready = (state_q == ST_RUN);
        halted      = (state_q == ST_HALTED);
        wb_en       = 1'b0;
        wb_idx      = f_rd;
        wb_data     = alu_res;
        br_taken    = 1'b0;
        br_target   = alu_tgt;
        illegal     = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = alu_addr;
        mem_wdata   = rd_val;
        unique case (state_q)
            ST_RUN: begin
                if (instr_valid) begin
                    illegal  = (dec.cls == CLS_ILLEGAL);
                    wb_en    = dec.writes_reg;
                    br_taken = (dec.cls == CLS_BRANCH) && alu_br;
                    mem_req  = (dec.cls == CLS_LOAD) || (dec.cls == CLS_STORE);
                    mem_we   = (dec.cls == CLS_STORE);
                end
            end
            ST_LOAD_WAIT: begin
                wb_en   = ld_valid;
                wb_idx  = ld_dest_q;
                wb_data = ld_data;
            end
            ST_HALTED: begin
                wb_en = 1'b0;
            end
            default: begin
                wb_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcx_exec_chk.sv
module bcx_exec_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_ready,
    input logic wb_en,
    input logic br_taken,
    input logic halted,
    input logic illegal,
    input logic mem_req,
    input logic mem_we
);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(wb_en || mem_req || br_taken));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(wb_en || mem_req || br_taken));

    // R9
    load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !instr_ready);

    // R9
    req_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> instr_ready);

    // R7
    branch_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> !(wb_en || mem_req));

endmodule

bind bcx_exec_unit bcx_exec_chk u_exec_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_ready (instr_ready),
    .wb_en       (wb_en),
    .br_taken    (br_taken),
    .halted      (halted),
    .illegal     (illegal),
    .mem_req     (mem_req),
    .mem_we      (mem_we)
);

// File: tb/bcx_exec_unit_tb.sv
module bcx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        instr_ready;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        br_taken;
    logic [31:0] br_target;
    logic        halted;
    logic        illegal;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bcx_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .instr_ready(instr_ready), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .br_taken(br_taken), .br_target(br_target), .halted(halted), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic        wb;
        logic [31:0] wd;
        logic        br;
        logic [31:0] tg;
        logic        ill;
        logic        mr;
        logic        mw;
        logic [31:0] ma;
        logic [31:0] md;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        // R2 set.high clear / set.low keep / set.high fill / set.low fill
        '{32'h101000A0, 1, 32'h00A00000, 0, 0, 0, 0, 0, 0, 0, 2},
        '{32'h11115600, 1, 32'h00A05600, 0, 0, 0, 0, 0, 0, 0, 2},
        '{32'h102F1234, 1, 32'h1234FFFF, 0, 0, 0, 0, 0, 0, 0, 2},
        '{32'h113F8000, 1, 32'hFFFF8000, 0, 0, 0, 0, 0, 0, 0, 2},
        // R3 copy
        '{32'h12410000, 1, 32'h00A05600, 0, 0, 0, 0, 0, 0, 0, 3},
        // R4 add.u, add.s, sub.u, sub.s
        '{32'h21512FFF, 1, 32'h12D565FE, 0, 0, 0, 0, 0, 0, 0, 4},
        '{32'h20612FFF, 1, 32'h12D555FE, 0, 0, 0, 0, 0, 0, 0, 4},
        '{32'h23721001, 1, 32'h1194A9FE, 0, 0, 0, 0, 0, 0, 0, 4},
        '{32'h22812800, 1, 32'hEE6B5E01, 0, 0, 0, 0, 0, 0, 0, 4},
        // R5 and, or, xor, not
        '{32'h40912000, 1, 32'h00205600, 0, 0, 0, 0, 0, 0, 0, 5},
        '{32'h41A13000, 1, 32'hFFFFD600, 0, 0, 0, 0, 0, 0, 0, 5},
        '{32'h42B23000, 1, 32'hEDCB7FFF, 0, 0, 0, 0, 0, 0, 0, 5},
        '{32'h43C10000, 1, 32'hFF5FA9FF, 0, 0, 0, 0, 0, 0, 0, 5},
        // R6 shift amount setup, asr, lsr, asl, lsl, amount 36 uses only 4
        '{32'h11D00004, 1, 32'h00000004, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h49E3D000, 1, 32'hFFFFF800, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h4BE3D000, 1, 32'h0FFFF800, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h48E1D000, 1, 32'h0A056000, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h4AF2D000, 1, 32'h234FFFF0, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h11D00024, 1, 32'h00000024, 0, 0, 0, 0, 0, 0, 0, 6},
        '{32'h4BE3D000, 1, 32'h0FFFF800, 0, 0, 0, 0, 0, 0, 0, 6},
        // R7 beq taken, bne not, bgt signed taken, bgt not
        '{32'h50414FF0, 0, 0, 1, 32'h00A055F0, 0, 0, 0, 0, 0, 7},
        '{32'h51414FF0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7},
        '{32'h52413010, 0, 0, 1, 32'h00A05610, 0, 0, 0, 0, 0, 7},
        '{32'h52431010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7},
        // R8 store with negative offset
        '{32'h1821FFF0, 0, 0, 0, 0, 0, 1, 1, 32'h00A055F0, 32'h1234FFFF, 8},
        // R11 reserved, user-defined, multiply, bad set mode, then r2 unchanged
        '{32'h05000000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 11},
        '{32'h80000000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 11},
        '{32'h24512000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 11},
        '{32'h10220000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 11},
        '{32'h18210000, 0, 0, 0, 0, 0, 1, 1, 32'h00A05600, 32'h1234FFFF, 11}
    };

    // Drive after the edge, sample mid-cycle.
    task automatic drive(input logic v, input logic [31:0] ins, input logic lv, input logic [31:0] ld);
        @(posedge clk);
        #2;
        instr_valid = v;
        instr       = ins;
        ld_valid    = lv;
        ld_data     = ld;
        #3;
    endtask

    task automatic expect1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v);
        string tag;
        logic ok;
        tag = $sformatf("R%0d", v.req);
        ok = (wb_en === v.wb) && (br_taken === v.br) && (illegal === v.ill) && (mem_req === v.mr);
        if (v.wb) ok = ok && (wb_data === v.wd) && (wb_idx === v.ins[23:20]);
        if (v.br) ok = ok && (br_target === v.tg);
        if (v.mr) ok = ok && (mem_we === v.mw) && (mem_addr === v.ma) && (mem_wdata === v.md);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s instr %h: actual wb=%b/%h br=%b/%h ill=%b mem=%b%b/%h/%h expected wb=%b/%h br=%b/%h ill=%b mem=%b%b/%h/%h",
                     tag, v.ins, wb_en, wb_data, br_taken, br_target, illegal, mem_req, mem_we, mem_addr, mem_wdata,
                     v.wb, v.wd, v.br, v.tg, v.ill, v.mr, v.mw, v.ma, v.md);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state and a never-written register read out through a store
        drive(1, 32'h18500000, 0, 0);
        expect1("R1", "halted", {31'b0, halted}, 32'h0);
        expect1("R1", "instr_ready", {31'b0, instr_ready}, 32'h1);
        expect1("R1", "r5 after reset", mem_wdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(1, VEC[i].ins, 0, 0);
            check_vec(VEC[i]);
        end

        // R9 load request
        drive(1, 32'h14610004, 0, 0);
        expect1("R9", "load req/we", {30'b0, mem_req, mem_we}, 32'h2);
        expect1("R9", "load addr", mem_addr, 32'h00A05604);
        // R9 instruction offered while waiting is dropped
        drive(1, 32'h12710000, 0, 0);
        expect1("R9", "ready while waiting", {31'b0, instr_ready}, 32'h0);
        expect1("R9", "no write while waiting", {31'b0, wb_en}, 32'h0);
        // R9 data return
        drive(0, 32'h0, 1, 32'hCAFEF00D);
        expect1("R9", "return write", {27'b0, wb_en, wb_idx}, 32'h16);
        expect1("R9", "return data", wb_data, 32'hCAFEF00D);
        drive(1, 32'h18610000, 0, 0);
        expect1("R9", "ready after return", {31'b0, instr_ready}, 32'h1);
        expect1("R9", "r6 holds load", mem_wdata, 32'hCAFEF00D);
        drive(1, 32'h18710000, 0, 0);
        expect1("R9", "r7 untouched", mem_wdata, 32'h1194A9FE);

        // R10 halt
        drive(1, 32'h00FFFFFF, 0, 0);
        expect1("R10", "halt no side effect", {29'b0, wb_en, mem_req, illegal}, 32'h0);
        drive(1, 32'h11500000, 0, 0);
        expect1("R10", "halted", {31'b0, halted}, 32'h1);
        expect1("R10", "no write", {31'b0, wb_en}, 32'h0);
        drive(1, 32'h18210000, 0, 0);
        expect1("R10", "no store", {31'b0, mem_req}, 32'h0);
        drive(1, 32'h50414FF0, 0, 0);
        expect1("R10", "no branch, still halted", {30'b0, br_taken, halted}, 32'h1);

        // R1 reset leaves halt and clears registers
        rst_n = 1'b0;
        #10;
        rst_n = 1'b1;
        drive(1, 32'h18100000, 0, 0);
        expect1("R1", "halted after reset", {31'b0, halted}, 32'h0);
        expect1("R1", "r1 cleared", mem_wdata, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule